// File: doc/BRIEF.md
# Machine-Cycle Bus Strobe Generator

This block produces the timing strobes for a multiplexed external bus of an 8-bit controller core. A machine cycle is twelve oscillator clocks, split into six states of two clocks each. In every cycle the block emits address-latch pulses that the board uses to capture the low address byte. When code comes from outside, it also emits program-store read strobes. In cycles that access external data memory, it emits a read or write strobe in place of the pulses that cycle gives up.

The core gives the block a small context at each cycle boundary:
- the fetch address;
- the external-access pin level;
- whether the cycle is an external data access, and its direction;
- whether a code-memory table read is in progress;
- the latch-disable control bit.

The block registers this context on the clock edge that opens the cycle and holds it for the whole cycle. The strobes are then decoded from a free-running clock counter and the held context. Address and data generation, and instruction decode, are not part of this block.

Top module: `mc_bus_strobe_gen`

## Requirements
- R1: In a cycle that is not an external data access and is not suppressed by the disable bit, ale_o is high at clock indices 0–1 and 6–7 of the twelve-clock cycle, and low at every other index. Index 0 is the first clock after the cycle-opening edge. The expected pattern, with bit i being index i, is 12'h0C3.
- R2: In an external data cycle, the second latch pulse is dropped. ale_o is high only at indices 0–1 (pattern 12'h003).
- R3: When the cycle's fetch is external and the cycle is not a data access, psen_n_o is low at indices 2–4 and 8–10 (pattern 12'h8E3). When the fetch is internal, psen_n_o stays high.
- R4: In an external data cycle, psen_n_o stays high for all twelve clocks, whatever the fetch source.
- R5: An external data read drives rd_n_o low at indices 6–11 (pattern 12'h03F), with xdata_wr_i = 0. A write does the same on wr_n_o, with xdata_wr_i = 1. The two strobes are never low together.
- R6: The fetch counts as external when ea_i is 0. It also counts as external when fetch_addr_i is 16'h1000 or above. Addresses 16'h0000–16'h0FFF with ea_i = 1 are internal.
- R7: With ale_dis_i = 1 and an internal fetch, ale_o is held high for the whole cycle. The exception is a cycle with movc_i = 1 or xdata_i = 1, which pulses as in R1 and R2.
- R8: With an external fetch, ale_dis_i has no effect, and ale_o follows R1 and R2.
- R9: While rst_ni is low, ale_o = 0 and psen_n_o, rd_n_o and wr_n_o are 1, and reset acts at once (asynchronously). The first clock edge after release opens a new cycle at index 0.
- R10: All cycle inputs are sampled only on the edge that opens a cycle. Changes at any other time do not affect the current cycle's strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ea_i | input | 1 | External-access pin; 0 forces all fetches external |
| fetch_addr_i | input | 16 | Code address fetched in the coming cycle |
| xdata_i | input | 1 | Coming cycle is an external data access |
| xdata_wr_i | input | 1 | Direction of the data access: 1 write, 0 read |
| movc_i | input | 1 | Coming cycle is a code-memory table read |
| ale_dis_i | input | 1 | Latch-disable control bit |
| ale_o | output | 1 | Address latch strobe, active high |
| psen_n_o | output | 1 | Program-store read strobe, active low |
| rd_n_o | output | 1 | External data read strobe, active low |
| wr_n_o | output | 1 | External data write strobe, active low |

## Verification
The assertions check on every cycle that:
- the read and write strobes never overlap;
- the program strobe never fires during a data strobe or a latch pulse;
- latch pulses last at least two clocks, and program strobes at least two;
- the counter wraps cleanly;
- the held context changes only on a cycle-opening edge.

The exact clock index of each edge, the dropped second pulse, the address boundary at 0x1000, and the precedence between the disable bit and an external fetch can only be shown by the bench. The bench compares whole twelve-clock patterns per cycle. It also toggles every input in mid-cycle and applies reset in the middle of a data strobe.

// File: rtl/mc_strobe_pkg.sv
package mc_strobe_pkg;
  localparam int unsigned STATES_PER_CYC = 6;

  typedef struct packed {
    logic ext_fetch;
    logic xdata;
    logic xwr;
    logic movc;
    logic ale_dis;
  } cyc_ctx_t;
endpackage

// File: rtl/mc_cycle_timer.sv
module mc_cycle_timer
  import mc_strobe_pkg::*;
#(
  parameter int unsigned CLKS_PER_STATE = 2,
  parameter int unsigned PSEN_CLKS      = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic cyc_open_o,
  output logic ale_slot_a_o,
  output logic ale_slot_b_o,
  output logic psen_slot_o,
  output logic data_slot_o
);
  localparam int unsigned CYC_CLKS = STATES_PER_CYC * CLKS_PER_STATE;
  localparam int unsigned HALF     = CYC_CLKS / 2;
  localparam int unsigned IDX_W    = $clog2(CYC_CLKS);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(CYC_CLKS - 1);

  logic [IDX_W-1:0] idx_q;
  logic [1:0]       ale_win, psen_win;

  // parked at the last clock so the first edge after reset opens state 1
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            idx_q <= LAST;
    else if (idx_q == LAST) idx_q <= '0;
    else                    idx_q <= idx_q + 1'b1;
  end

  for (genvar w = 0; w < 2; w++) begin : g_win
    localparam int unsigned BASE = w * HALF;
    assign ale_win[w]  = (idx_q >= IDX_W'(BASE)) &&
                         (idx_q <  IDX_W'(BASE + CLKS_PER_STATE));
    assign psen_win[w] = (idx_q >= IDX_W'(BASE + CLKS_PER_STATE)) &&
                         (idx_q <  IDX_W'(BASE + CLKS_PER_STATE + PSEN_CLKS));
  end

  assign cyc_open_o   = (idx_q == LAST);
  assign ale_slot_a_o = ale_win[0];
  assign ale_slot_b_o = ale_win[1];
  assign psen_slot_o  = |psen_win;
  assign data_slot_o  = (idx_q >= IDX_W'(HALF));

  p_wrap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_q == LAST) |=> (idx_q == '0));
  p_idx_range_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= LAST);
endmodule

// File: rtl/mc_cycle_ctx.sv
module mc_cycle_ctx
  import mc_strobe_pkg::*;
#(
  parameter int unsigned ADDR_W         = 16,
  parameter int unsigned INT_CODE_BYTES = 4096
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              ea_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  input  logic              xdata_i,
  input  logic              xdata_wr_i,
  input  logic              movc_i,
  input  logic              ale_dis_i,
  output cyc_ctx_t          ctx_o
);
  localparam logic [ADDR_W:0] INT_LIM = (ADDR_W + 1)'(INT_CODE_BYTES);

  cyc_ctx_t ctx_q, ctx_d;

  always_comb begin
    ctx_d.ext_fetch = !ea_i || ({1'b0, fetch_addr_i} >= INT_LIM);
    ctx_d.xdata     = xdata_i;
    ctx_d.xwr       = xdata_wr_i;
    ctx_d.movc      = movc_i;
    ctx_d.ale_dis   = ale_dis_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ctx_q <= '0;
    else if (load_i) ctx_q <= ctx_d;
  end

  assign ctx_o = ctx_q;

  p_ctx_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(ctx_q));
  p_ea_low_ext_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !ea_i) |=> ctx_q.ext_fetch);
endmodule

// File: rtl/mc_strobe_decode.sv
module mc_strobe_decode
  import mc_strobe_pkg::*;
(
  input  cyc_ctx_t ctx_i,
  input  logic     ale_slot_a_i,
  input  logic     ale_slot_b_i,
  input  logic     psen_slot_i,
  input  logic     data_slot_i,
  output logic     ale_o,
  output logic     psen_n_o,
  output logic     rd_n_o,
  output logic     wr_n_o
);
  logic ale_held_hi, ale_pulse;

  // disable bit only bites on internal fetch, and never in MOVX/MOVC cycles
  assign ale_held_hi = ctx_i.ale_dis && !ctx_i.ext_fetch && !(ctx_i.xdata || ctx_i.movc);
  assign ale_pulse   = ale_slot_a_i || (ale_slot_b_i && !ctx_i.xdata);

  assign ale_o    = ale_held_hi || ale_pulse;
  assign psen_n_o = !(ctx_i.ext_fetch && !ctx_i.xdata && psen_slot_i);
  assign rd_n_o   = !(ctx_i.xdata && !ctx_i.xwr && data_slot_i);
  assign wr_n_o   = !(ctx_i.xdata &&  ctx_i.xwr && data_slot_i);
endmodule

// File: rtl/mc_bus_strobe_gen.sv
module mc_bus_strobe_gen
  import mc_strobe_pkg::*;
#(
  parameter int unsigned CLKS_PER_STATE = 2,
  parameter int unsigned PSEN_CLKS      = 3,
  parameter int unsigned ADDR_W         = 16,
  parameter int unsigned INT_CODE_BYTES = 4096
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ea_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  input  logic              xdata_i,
  input  logic              xdata_wr_i,
  input  logic              movc_i,
  input  logic              ale_dis_i,
  output logic              ale_o,
  output logic              psen_n_o,
  output logic              rd_n_o,
  output logic              wr_n_o
);
  logic     cyc_open, slot_a, slot_b, psen_slot, data_slot;
  cyc_ctx_t ctx;

  mc_cycle_timer #(
    .CLKS_PER_STATE(CLKS_PER_STATE),
    .PSEN_CLKS     (PSEN_CLKS)
  ) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cyc_open_o  (cyc_open),
    .ale_slot_a_o(slot_a),
    .ale_slot_b_o(slot_b),
    .psen_slot_o (psen_slot),
    .data_slot_o (data_slot)
  );

  mc_cycle_ctx #(
    .ADDR_W        (ADDR_W),
    .INT_CODE_BYTES(INT_CODE_BYTES)
  ) u_ctx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (cyc_open),
    .ea_i        (ea_i),
    .fetch_addr_i(fetch_addr_i),
    .xdata_i     (xdata_i),
    .xdata_wr_i  (xdata_wr_i),
    .movc_i      (movc_i),
    .ale_dis_i   (ale_dis_i),
    .ctx_o       (ctx)
  );

  mc_strobe_decode u_dec (
    .ctx_i       (ctx),
    .ale_slot_a_i(slot_a),
    .ale_slot_b_i(slot_b),
    .psen_slot_i (psen_slot),
    .data_slot_i (data_slot),
    .ale_o       (ale_o),
    .psen_n_o    (psen_n_o),
    .rd_n_o      (rd_n_o),
    .wr_n_o      (wr_n_o)
  );

  p_rd_wr_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_n_o && !wr_n_o));
  p_data_no_psen_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_n_o || !wr_n_o) |-> psen_n_o);
  p_ale_width_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ale_o) |=> ale_o);
  p_psen_width_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(psen_n_o) |=> !psen_n_o);
  p_psen_not_ale_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !psen_n_o |-> !ale_o);
  p_rd_width_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rd_n_o) |=> !rd_n_o);
endmodule

// File: tb/mc_bus_strobe_gen_tb_top.sv
`timescale 1ns/1ps
module mc_bus_strobe_gen_tb_top;
  typedef struct packed {
    logic        ea;
    logic [15:0] addr;
    logic        xd;
    logic        wr;
    logic        movc;
    logic        dis;
    logic [11:0] ale;
    logic [11:0] psen;
    logic [11:0] rd;
    logic [11:0] wrs;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 16'h0100, 1'b0, 1'b0, 1'b0, 1'b0, 12'h0C3, 12'hFFF, 12'hFFF, 12'hFFF, 4'd1},
    '{1'b1, 16'h1000, 1'b0, 1'b0, 1'b0, 1'b0, 12'h0C3, 12'h8E3, 12'hFFF, 12'hFFF, 4'd3},
    '{1'b0, 16'h0010, 1'b0, 1'b0, 1'b0, 1'b0, 12'h0C3, 12'h8E3, 12'hFFF, 12'hFFF, 4'd6},
    '{1'b1, 16'h0FFF, 1'b0, 1'b0, 1'b0, 1'b0, 12'h0C3, 12'hFFF, 12'hFFF, 12'hFFF, 4'd6},
    '{1'b1, 16'h2000, 1'b1, 1'b0, 1'b0, 1'b0, 12'h003, 12'hFFF, 12'h03F, 12'hFFF, 4'd4},
    '{1'b1, 16'h0200, 1'b1, 1'b1, 1'b0, 1'b0, 12'h003, 12'hFFF, 12'hFFF, 12'h03F, 4'd5},
    '{1'b1, 16'h0200, 1'b0, 1'b0, 1'b0, 1'b1, 12'hFFF, 12'hFFF, 12'hFFF, 12'hFFF, 4'd7},
    '{1'b1, 16'h0200, 1'b0, 1'b0, 1'b1, 1'b1, 12'h0C3, 12'hFFF, 12'hFFF, 12'hFFF, 4'd7},
    '{1'b1, 16'h0200, 1'b1, 1'b0, 1'b0, 1'b1, 12'h003, 12'hFFF, 12'h03F, 12'hFFF, 4'd2},
    '{1'b0, 16'h0200, 1'b0, 1'b0, 1'b0, 1'b1, 12'h0C3, 12'h8E3, 12'hFFF, 12'hFFF, 4'd8},
    '{1'b1, 16'hF000, 1'b0, 1'b0, 1'b0, 1'b1, 12'h0C3, 12'h8E3, 12'hFFF, 12'hFFF, 4'd8},
    '{1'b0, 16'h0200, 1'b1, 1'b1, 1'b0, 1'b1, 12'h003, 12'hFFF, 12'hFFF, 12'h03F, 4'd8}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ea, xd, xwr, movc, dis;
  logic [15:0] addr;
  logic        ale, psen_n, rd_n, wr_n;
  int          n_chk = 0;
  int          n_bad = 0;

  always #4 clk = ~clk;

  mc_bus_strobe_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ea_i(ea), .fetch_addr_i(addr),
    .xdata_i(xd), .xdata_wr_i(xwr), .movc_i(movc), .ale_dis_i(dis),
    .ale_o(ale), .psen_n_o(psen_n), .rd_n_o(rd_n), .wr_n_o(wr_n)
  );

  function automatic string req_name(input logic [3:0] r);
    case (r)
      4'd1:    return "R1";
      4'd2:    return "R2";
      4'd3:    return "R3";
      4'd4:    return "R4";
      4'd5:    return "R5";
      4'd6:    return "R6";
      4'd7:    return "R7";
      4'd8:    return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [11:0] act, input logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v, input bit inv);
    ea   = v.ea   ^ inv;
    addr = v.addr ^ {16{inv}};
    xd   = v.xd   ^ inv;
    xwr  = v.wr   ^ inv;
    movc = v.movc ^ inv;
    dis  = v.dis  ^ inv;
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [11:0] s_ale, s_psen, s_rd, s_wr;
    rst_n = 1'b0;
    drive(VECS[0], 1'b0);
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9", "ale in reset",  {11'd0, ale},    12'd0);
    check("R9", "psen in reset", {11'd0, psen_n}, 12'd1);
    check("R9", "rd in reset",   {11'd0, rd_n},   12'd1);
    check("R9", "wr in reset",   {11'd0, wr_n},   12'd1);
    rst_n = 1'b1;

    // table walk; inputs inverted at index 3 and restored at 11 (R10)
    for (int k = 0; k < NV; k++) begin
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        s_ale[i]  = ale;
        s_psen[i] = psen_n;
        s_rd[i]   = rd_n;
        s_wr[i]   = wr_n;
        if (i == 3) drive(VECS[k], 1'b1);
        if (i == 11) drive(VECS[(k == NV - 1) ? 4 : k + 1], 1'b0);
      end
      check({req_name(VECS[k].req), " R10"}, $sformatf("ale vec%0d", k),  s_ale,  VECS[k].ale);
      check({req_name(VECS[k].req), " R10"}, $sformatf("psen vec%0d", k), s_psen, VECS[k].psen);
      check({req_name(VECS[k].req), " R5"},  $sformatf("rd vec%0d", k),   s_rd,   VECS[k].rd);
      check({req_name(VECS[k].req), " R5"},  $sformatf("wr vec%0d", k),   s_wr,   VECS[k].wrs);
    end

    // R9: reset in the middle of a read strobe, then restart at index 0
    repeat (9) @(negedge clk);
    check("R5", "rd low at idx8", {11'd0, rd_n}, 12'd0);
    rst_n = 1'b0;
    #1;
    check("R9", "rd after async reset",  {11'd0, rd_n}, 12'd1);
    check("R9", "ale after async reset", {11'd0, ale},  12'd0);
    drive(VECS[1], 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", "ale at idx0 after release",  {11'd0, ale},    12'd1);
    check("R9", "psen at idx0 after release", {11'd0, psen_n}, 12'd1);
    repeat (2) @(negedge clk);
    check("R3", "psen at idx2 after release", {11'd0, psen_n}, 12'd0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule